// File: doc/BRIEF.md
# Trap Delegation Router

This block picks the privilege level that services each trap on a hart that has machine and user modes, and optionally a supervisor mode. It holds the machine-level exception and interrupt delegation masks and, when the supervisor mode is configured, the supervisor-level masks as well. All four masks are reached through a small CSR port. For each trap strobe it reports the target mode one cycle later.

A trap is routed to a lower level only when the delegation masks allow it and the hart is running at or below that level. A trap is never routed below the mode the hart is currently in. The supervisor masks can only hold bits that the machine level has already handed down. Clearing a machine bit also clears the matching supervisor bit, so a stale user delegation cannot survive.

Top module: `trap_deleg_router`

## Requirements
- R1: After a synchronous active-low reset, all four delegation masks read zero and `route_valid` is low.
- R2: `csr_sel` selects a mask: 0 = machine exceptions, 1 = machine interrupts, 2 = supervisor exceptions, 3 = supervisor interrupts. A write with `csr_we` high takes effect at the clock edge. `csr_rdata` always shows the selected mask, and the machine masks store all 16 bits.
- R3: A write to a supervisor mask stores `csr_wdata` ANDed with the matching machine mask. Bits whose machine bit is clear read as zero.
- R4: A write to a machine mask clears, in the same cycle, every supervisor bit whose new machine bit is zero. Setting a machine bit again does not restore the supervisor bit.
- R5: With `HAS_SMODE` = 0, the supervisor masks always read zero and writes to them are ignored.
- R6: `route_valid` equals `trap_valid` delayed by one cycle. `route_mode` is valid in the same cycle and uses the encoding user = 0, supervisor = 1, machine = 3.
- R7: A trap whose machine delegation bit is clear is routed to machine mode.
- R8: With the supervisor mode present, a trap that is delegated by the machine mask but not by the supervisor mask, taken in supervisor or user mode, is routed to supervisor mode.
- R9: With the supervisor mode present, a trap that is delegated by both masks is routed to user mode when taken in user mode, and to supervisor mode when taken in supervisor mode.
- R10: A trap taken in machine mode (`cur_mode` = 3) is always routed to machine mode, and no target is ever below the current mode.
- R11: With `HAS_SMODE` = 0, a trap whose machine bit is set goes to user mode only when taken in user mode, and to machine mode otherwise. Supervisor mode is never reported.
- R12: Exceptions index the exception masks by `trap_cause`, and interrupts index the interrupt masks by `trap_cause`. The two masks are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Mask write strobe |
| csr_sel | input | 2 | Mask select (see R2) |
| csr_wdata | input | MASK_W | Write data |
| csr_rdata | output | MASK_W | Selected mask contents |
| trap_valid | input | 1 | Trap strobe |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | log2(MASK_W) | Cause code or interrupt number |
| cur_mode | input | 2 | Current privilege mode (0 U, 1 S, 3 M) |
| route_valid | output | 1 | Routing result valid |
| route_mode | output | 2 | Target mode for the trap |

## Verification
A wrong bit in any machine or supervisor mask shows up at `csr_rdata` as soon as that mask is selected. It also shows up at `route_mode` one cycle after any trap with the matching cause and kind. A supervisor bit that was not cleared when its machine bit dropped shows up in two ways: on read-back, and as a user or supervisor target after the machine bit is set again. The bench therefore checks each routing case against both a supervisor-capable instance and a machine-plus-user instance, and reads back the masks after every write that masks or clears bits.

// File: rtl/tdr_pkg.sv
// Shared types for the trap delegation router.
// Assumes the privilege encoding U=0, S=1, M=3; value 2 is treated as machine.
package tdr_pkg;
    typedef enum logic [1:0] {
        MODE_U   = 2'b00,
        MODE_S   = 2'b01,
        MODE_RSV = 2'b10,
        MODE_M   = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        SEL_MEXC = 2'd0,
        SEL_MINT = 2'd1,
        SEL_SEXC = 2'd2,
        SEL_SINT = 2'd3
    } csr_sel_e;
endpackage

// File: rtl/tdr_regs.sv
// Delegation mask storage with CSR access.
// Holds the machine masks always and the supervisor masks when HAS_SMODE is set.
// Supervisor bits are kept a subset of the machine bits on every write.
module tdr_regs
    import tdr_pkg::*;
#(
    parameter int MASK_W    = 16,
    parameter bit HAS_SMODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [1:0]        csr_sel,
    input  logic [MASK_W-1:0] csr_wdata,
    output logic [MASK_W-1:0] csr_rdata,
    output logic [MASK_W-1:0] m_exc,
    output logic [MASK_W-1:0] m_int,
    output logic [MASK_W-1:0] s_exc,
    output logic [MASK_W-1:0] s_int
);
    csr_sel_e sel;
    assign sel = csr_sel_e'(csr_sel);

    logic wr_mexc, wr_mint, wr_sexc, wr_sint;
    assign wr_mexc = csr_we && (sel == SEL_MEXC);
    assign wr_mint = csr_we && (sel == SEL_MINT);
    assign wr_sexc = csr_we && (sel == SEL_SEXC);
    assign wr_sint = csr_we && (sel == SEL_SINT);

    // Machine masks: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_exc <= '0;
            m_int <= '0;
        end else begin
            if (wr_mexc) m_exc <= csr_wdata;
            if (wr_mint) m_int <= csr_wdata;
        end
    end

    generate
        if (HAS_SMODE) begin : g_smode
            // Supervisor masks: writes gated by machine bits, pruned when machine bits drop.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s_exc <= '0;
                    s_int <= '0;
                end else begin
                    if (wr_sexc)      s_exc <= csr_wdata & m_exc;
                    else if (wr_mexc) s_exc <= s_exc & csr_wdata;
                    if (wr_sint)      s_int <= csr_wdata & m_int;
                    else if (wr_mint) s_int <= s_int & csr_wdata;
                end
            end

            // R3
            s_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ((s_exc & ~m_exc) == '0) && ((s_int & ~m_int) == '0));

            // R4
            prune_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_mexc |=> ((s_exc & ~$past(csr_wdata)) == '0));
        end else begin : g_no_smode
            // No supervisor level: masks are constant zero.
            assign s_exc = '0;
            assign s_int = '0;
        end
    endgenerate

    // Read mux for the selected mask.
    always_comb begin
        unique case (sel)
            SEL_MEXC: csr_rdata = m_exc;
            SEL_MINT: csr_rdata = m_int;
            SEL_SEXC: csr_rdata = s_exc;
            default:  csr_rdata = s_int;
        endcase
    end
endmodule

// File: rtl/tdr_route.sv
// Routing decision for one trap per cycle, registered to the output.
// Assumes masks are stable in the cycle the trap is presented.
module tdr_route
    import tdr_pkg::*;
#(
    parameter int MASK_W    = 16,
    parameter bit HAS_SMODE = 1'b1,
    localparam int CAUSE_W  = $clog2(MASK_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid,
    input  logic               trap_is_irq,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [1:0]         cur_mode,
    input  logic [MASK_W-1:0]  m_exc,
    input  logic [MASK_W-1:0]  m_int,
    input  logic [MASK_W-1:0]  s_exc,
    input  logic [MASK_W-1:0]  s_int,
    output logic               route_valid,
    output logic [1:0]         route_mode
);
    logic  m_bit, s_bit;
    priv_e cur, target;

    assign cur   = priv_e'(cur_mode);
    assign m_bit = trap_is_irq ? m_int[trap_cause] : m_exc[trap_cause];
    assign s_bit = trap_is_irq ? s_int[trap_cause] : s_exc[trap_cause];

    // Choose the lowest permitted handler level not below the current mode.
    always_comb begin
        target = MODE_M;
        if (m_bit) begin
            if (HAS_SMODE) begin
                if (cur == MODE_U)      target = s_bit ? MODE_U : MODE_S;
                else if (cur == MODE_S) target = MODE_S;
            end else if (cur == MODE_U) begin
                target = MODE_U;
            end
        end
    end

    // Register the decision with its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_valid <= 1'b0;
            route_mode  <= MODE_M;
        end else begin
            route_valid <= trap_valid;
            if (trap_valid) route_mode <= target;
        end
    end

    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid == $past(trap_valid));

    // R10
    no_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> (route_mode >= $past(cur_mode)));

    // R9
    user_only_from_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_valid && route_mode == MODE_U) |-> ($past(cur_mode) == MODE_U));

    generate
        if (!HAS_SMODE) begin : g_chk_nos
            // R11
            no_smode_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
                route_valid |-> (route_mode != MODE_S));
        end
    endgenerate
endmodule

// File: rtl/trap_deleg_router.sv
// Top of the trap delegation router: mask storage plus routing decision.
// Assumes one trap at most per cycle; result appears one cycle after the strobe.
module trap_deleg_router #(
    parameter int MASK_W    = 16,
    parameter bit HAS_SMODE = 1'b1,
    localparam int CAUSE_W  = $clog2(MASK_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic [1:0]         csr_sel,
    input  logic [MASK_W-1:0]  csr_wdata,
    output logic [MASK_W-1:0]  csr_rdata,
    input  logic               trap_valid,
    input  logic               trap_is_irq,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [1:0]         cur_mode,
    output logic               route_valid,
    output logic [1:0]         route_mode
);
    logic [MASK_W-1:0] m_exc, m_int, s_exc, s_int;

    tdr_regs #(.MASK_W(MASK_W), .HAS_SMODE(HAS_SMODE)) u_regs (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .m_exc(m_exc), .m_int(m_int), .s_exc(s_exc), .s_int(s_int)
    );

    tdr_route #(.MASK_W(MASK_W), .HAS_SMODE(HAS_SMODE)) u_route (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid),
        .trap_is_irq(trap_is_irq), .trap_cause(trap_cause), .cur_mode(cur_mode),
        .m_exc(m_exc), .m_int(m_int), .s_exc(s_exc), .s_int(s_int),
        .route_valid(route_valid), .route_mode(route_mode)
    );
endmodule

// File: tb/sim_trap_deleg_router.sv
module sim_trap_deleg_router;
    localparam int MW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_we = 1'b0;
    logic [1:0]    csr_sel = 2'd0;
    logic [MW-1:0] csr_wdata = '0;
    logic          trap_valid = 1'b0;
    logic          trap_is_irq = 1'b0;
    logic [CW-1:0] trap_cause = '0;
    logic [1:0]    cur_mode = 2'd0;
    logic [MW-1:0] rd_s, rd_n;
    logic          rv_s, rv_n;
    logic [1:0]    rm_s, rm_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    trap_deleg_router #(.MASK_W(MW), .HAS_SMODE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(rd_s), .trap_valid(trap_valid),
        .trap_is_irq(trap_is_irq), .trap_cause(trap_cause), .cur_mode(cur_mode),
        .route_valid(rv_s), .route_mode(rm_s));

    trap_deleg_router #(.MASK_W(MW), .HAS_SMODE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(rd_n), .trap_valid(trap_valid),
        .trap_is_irq(trap_is_irq), .trap_cause(trap_cause), .cur_mode(cur_mode),
        .route_valid(rv_n), .route_mode(rm_n));

    // vector: {irq, cause[3:0], cur[1:0], exp_with_s[1:0], exp_no_s[1:0]}
    localparam int NV = 13;
    localparam logic [10:0] VEC [NV] = '{
        {1'b0, 4'd4,  2'd0, 2'd0, 2'd0},   // R9 / R11 both delegated, user
        {1'b0, 4'd6,  2'd0, 2'd1, 2'd0},   // R8 / R11
        {1'b0, 4'd6,  2'd1, 2'd1, 2'd3},   // R8 / R11 from S
        {1'b0, 4'd4,  2'd1, 2'd1, 2'd3},   // R9 from S
        {1'b0, 4'd4,  2'd3, 2'd3, 2'd3},   // R10
        {1'b0, 4'd2,  2'd0, 2'd3, 2'd3},   // R7
        {1'b0, 4'd15, 2'd0, 2'd3, 2'd3},   // R7
        {1'b1, 4'd9,  2'd0, 2'd0, 2'd0},   // R9 irq
        {1'b1, 4'd11, 2'd0, 2'd1, 2'd0},   // R8 irq
        {1'b1, 4'd4,  2'd0, 2'd3, 2'd3},   // R12 irq mask differs
        {1'b1, 4'd9,  2'd3, 2'd3, 2'd3},   // R10 irq
        {1'b1, 4'd11, 2'd1, 2'd1, 2'd3},   // R8 irq from S
        {1'b0, 4'd9,  2'd0, 2'd3, 2'd3}    // R12 exc mask differs
    };

    task automatic check(input string req, input logic [MW-1:0] act, input logic [MW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [1:0] sel, input logic [MW-1:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_read(input logic [1:0] sel, output logic [MW-1:0] vs, output logic [MW-1:0] vn);
        csr_sel = sel;
        #1;
        vs = rd_s; vn = rd_n;
    endtask

    task automatic trap(input logic irq, input logic [CW-1:0] c, input logic [1:0] m);
        @(negedge clk);
        trap_valid = 1'b1; trap_is_irq = irq; trap_cause = c; cur_mode = m;
        @(negedge clk);
        trap_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [MW-1:0] a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 route_valid", {15'd0, rv_s}, 16'd0);
        for (int s = 0; s < 4; s++) begin
            csr_read(2'(s), a, b);
            check("R1 mask zero", a, 16'h0000);
        end

        // R2 machine masks full width
        csr_write(2'd0, 16'hFFFF);
        csr_read(2'd0, a, b);
        check("R2 mexc all ones", a, 16'hFFFF);
        csr_write(2'd0, 16'h00F0);
        csr_write(2'd1, 16'h0A00);
        csr_read(2'd0, a, b);
        check("R2 mexc", a, 16'h00F0);
        check("R2 mexc no-S", b, 16'h00F0);
        csr_read(2'd1, a, b);
        check("R2 mint", a, 16'h0A00);

        // R3 supervisor write masked by machine bits
        csr_write(2'd2, 16'hFF30);
        csr_read(2'd2, a, b);
        check("R3 sexc masked", a, 16'h0030);
        csr_write(2'd3, 16'hF2FF);
        csr_read(2'd3, a, b);
        check("R3 sint masked", a, 16'h0200);
        // R5 no supervisor storage
        check("R5 sint no-S", b, 16'h0000);
        csr_read(2'd2, a, b);
        check("R5 sexc no-S", b, 16'h0000);

        // R6 no strobe, no result
        @(negedge clk);
        check("R6 idle valid", {15'd0, rv_s}, 16'd0);

        // Table walk: R7..R12
        for (int i = 0; i < NV; i++) begin
            trap(VEC[i][10], VEC[i][9:6], VEC[i][5:4]);
            check("R6 valid", {15'd0, rv_s}, 16'd1);
            check($sformatf("R7-12 vec%0d with S", i), {14'd0, rm_s}, {14'd0, VEC[i][3:2]});
            check($sformatf("R11 vec%0d no S", i), {14'd0, rm_n}, {14'd0, VEC[i][1:0]});
        end
        @(negedge clk);
        check("R6 valid drops", {15'd0, rv_s}, 16'd0);

        // R4 clearing a machine bit prunes the supervisor bit permanently
        csr_write(2'd0, 16'h00E0);
        csr_read(2'd2, a, b);
        check("R4 sexc pruned", a, 16'h0020);
        csr_write(2'd0, 16'h00F0);
        csr_read(2'd2, a, b);
        check("R4 sexc stays pruned", a, 16'h0020);
        trap(1'b0, 4'd4, 2'd0);
        check("R4 exc4 now to S", {14'd0, rm_s}, 16'd1);
        trap(1'b0, 4'd5, 2'd0);
        check("R4 exc5 still to U", {14'd0, rm_s}, 16'd0);

        // R1 reset mid-run clears masks
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        csr_read(2'd0, a, b);
        check("R1 mexc after reset", a, 16'h0000);

        finish_run();
    end
endmodule